// File: doc/BRIEF.md
# USB Endpoint Control Register Bank

This block keeps one small control register for each of sixteen bidirectional USB endpoints. Software reads and writes the registers over a simple register bus: a 4-bit address, 8-bit write data, a write strobe and combinational read data. Each register sets four things for its endpoint. It enables handshakes, enables host OUT traffic, enables host IN traffic and blocks control (SETUP) transfers. It also holds a sticky stall flag.

The serial interface engine uses the bank in two ways. First, it asks an admission question in the same cycle. Given an endpoint number and a token kind, the bank answers whether the transaction may proceed, whether a handshake should be returned, and whether the endpoint is stalled. Second, it can mark an endpoint stalled through a one-cycle request. Once set, the stall flag is cleared only by a software write of 0 or by an engine reset pulse. The engine reset clears every stall flag and leaves the other bits alone.

Top module: `ep_ctl_bank`

## Requirements
- R1: After `rst_n` is released, every endpoint reads back as 8'h00 and no token is admitted.
- R2: Register fields are: bit 4 handshake enable, bit 3 control block, bit 2 OUT enable, bit 1 IN enable, bit 0 stall. A write stores bits 4..0 at the next clock edge. Bits 7..5 are ignored on write and always read as 0.
- R3: A write changes only the addressed endpoint. All other endpoints keep their values.
- R4: `q_hs` equals bit 4 of the queried endpoint.
- R5: `q_stalled` equals bit 0 of the queried endpoint.
- R6: Token codes are 2'b01 OUT, 2'b10 IN, 2'b11 SETUP and 2'b00 none. OUT is admitted exactly when bit 2 is 1. IN is admitted exactly when bit 1 is 1. Code 2'b00 is never admitted.
- R7: SETUP is admitted exactly when bits 2 and 1 are both 1 and bit 3 is 0.
- R8: A `stall_set` pulse sets bit 0 of endpoint `stall_ep` at the next edge and changes no other bit. The flag then stays set until a software write of 0 to bit 0 or an engine reset.
- R9: If a hardware stall-set and a software write clearing bit 0 hit the same endpoint in the same cycle, bit 0 ends up 1. The other written bits still take the written values.
- R10: An `sie_rst` pulse clears bit 0 of every endpoint at the next edge and leaves bits 4..1 unchanged. It overrides a `stall_set` in the same cycle, while a software write in that cycle still stores bits 4..1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sie_rst | input | 1 | Engine reset pulse; clears all stall flags |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register bus endpoint address (write and read) |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Combinational read data for `addr` |
| q_ep | input | 4 | Admission query endpoint number |
| q_tok | input | 2 | Admission query token code |
| q_allow | output | 1 | Token admitted |
| q_hs | output | 1 | Handshake to be returned |
| q_stalled | output | 1 | Queried endpoint is stalled |
| stall_set | input | 1 | Hardware request to stall an endpoint |
| stall_ep | input | 4 | Endpoint targeted by `stall_set` |

## Verification
The assertions assume that `addr` and `q_ep` stay constant across a clock edge whenever a check compares them over time. They also assume that all inputs are known once reset is released. The comparisons between the read path and the admission path hold only in cycles where `addr` equals `q_ep`. The bench drives every input on the falling edge and moves the addresses only while no update strobe is active. For each endpoint it sweeps all 256 write values and all four token codes. It also drives the same-cycle collisions of stall-set, software clear and engine reset on purpose.

// File: rtl/ep_ctl_pkg.sv
package ep_ctl_pkg;

    typedef enum logic [1:0] {
        TOK_NONE  = 2'b00,
        TOK_OUT   = 2'b01,
        TOK_IN    = 2'b10,
        TOK_SETUP = 2'b11
    } tok_e;

    typedef struct packed {
        logic hs_en;
        logic ctl_off;
        logic out_en;
        logic in_en;
        logic halt;
    } ep_cfg_t;

    localparam int CFG_W = $bits(ep_cfg_t);

endpackage

// File: rtl/ep_cfg_regs.sv
module ep_cfg_regs
    import ep_ctl_pkg::*;
#(
    parameter int NUM_EP = 16,
    parameter int AW     = $clog2(NUM_EP),
    parameter int DW     = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sie_rst,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [DW-1:0]            wdata,
    input  logic                     stall_set,
    input  logic [AW-1:0]            stall_ep,
    output ep_cfg_t [NUM_EP-1:0]     cfg_o
);

    typedef struct packed {
        ep_cfg_t [NUM_EP-1:0] ep;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_EP; i++) begin
            // software write first, hardware stall over it, engine reset last
            if (wr_en && wr_addr == AW'(i)) begin
                st_d.ep[i] = ep_cfg_t'(wdata[CFG_W-1:0]);
            end
            if (stall_set && stall_ep == AW'(i)) begin
                st_d.ep[i].halt = 1'b1;
            end
            if (sie_rst) begin
                st_d.ep[i].halt = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o = st_q.ep;

endmodule

// File: rtl/ep_rd_port.sv
module ep_rd_port
    import ep_ctl_pkg::*;
#(
    parameter int NUM_EP = 16,
    parameter int AW     = $clog2(NUM_EP),
    parameter int DW     = 8
) (
    input  ep_cfg_t [NUM_EP-1:0] cfg_i,
    input  logic [AW-1:0]        addr,
    output logic [DW-1:0]        rdata
);

    localparam int PAD_W = DW - CFG_W;

    generate
        if (PAD_W > 0) begin : g_pad
            assign rdata = {{PAD_W{1'b0}}, cfg_i[addr]};
        end else begin : g_nopad
            assign rdata = cfg_i[addr][DW-1:0];
        end
    endgenerate

endmodule

// File: rtl/ep_admit.sv
module ep_admit
    import ep_ctl_pkg::*;
#(
    parameter int NUM_EP = 16,
    parameter int AW     = $clog2(NUM_EP)
) (
    input  ep_cfg_t [NUM_EP-1:0] cfg_i,
    input  logic [AW-1:0]        q_ep,
    input  logic [1:0]           q_tok,
    output logic                 q_allow,
    output logic                 q_hs,
    output logic                 q_stalled
);

    ep_cfg_t sel;

    always_comb begin
        sel = cfg_i[q_ep];
        unique case (tok_e'(q_tok))
            TOK_OUT:   q_allow = sel.out_en;
            TOK_IN:    q_allow = sel.in_en;
            TOK_SETUP: q_allow = sel.out_en & sel.in_en & ~sel.ctl_off;
            default:   q_allow = 1'b0;
        endcase
        q_hs      = sel.hs_en;
        q_stalled = sel.halt;
    end

endmodule

// File: rtl/ep_ctl_bank.sv
module ep_ctl_bank
    import ep_ctl_pkg::*;
#(
    parameter int NUM_EP = 16,
    parameter int AW     = $clog2(NUM_EP),
    parameter int DW     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sie_rst,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [AW-1:0] q_ep,
    input  logic [1:0]    q_tok,
    output logic          q_allow,
    output logic          q_hs,
    output logic          q_stalled,
    input  logic          stall_set,
    input  logic [AW-1:0] stall_ep
);

    ep_cfg_t [NUM_EP-1:0] cfg;

    ep_cfg_regs #(.NUM_EP(NUM_EP), .AW(AW), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sie_rst   (sie_rst),
        .wr_en     (wr_en),
        .wr_addr   (addr),
        .wdata     (wdata),
        .stall_set (stall_set),
        .stall_ep  (stall_ep),
        .cfg_o     (cfg)
    );

    ep_rd_port #(.NUM_EP(NUM_EP), .AW(AW), .DW(DW)) u_rd (
        .cfg_i (cfg),
        .addr  (addr),
        .rdata (rdata)
    );

    ep_admit #(.NUM_EP(NUM_EP), .AW(AW)) u_admit (
        .cfg_i     (cfg),
        .q_ep      (q_ep),
        .q_tok     (q_tok),
        .q_allow   (q_allow),
        .q_hs      (q_hs),
        .q_stalled (q_stalled)
    );

endmodule

// File: rtl/ep_ctl_bank_chk.sv
module ep_ctl_bank_chk #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sie_rst,
    input logic          wr_en,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] wdata,
    input logic [DW-1:0] rdata,
    input logic [AW-1:0] q_ep,
    input logic [1:0]    q_tok,
    input logic          q_allow,
    input logic          q_hs,
    input logic          q_stalled,
    input logic          stall_set,
    input logic [AW-1:0] stall_ep
);

    AST_RESET_CLEAN: assert property (@(posedge clk) $rose(rst_n) |-> rdata == '0); // R1

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DW-1:5] == '0); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !stall_set && !sie_rst) |=> (addr != $past(addr)) || (rdata == $past(rdata))); // R3

    AST_HS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == q_ep) |-> q_hs == rdata[4]); // R4

    AST_STALL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == q_ep) |-> q_stalled == rdata[0]); // R5

    AST_IN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == q_ep && q_tok == 2'b10) |-> q_allow == rdata[1]); // R6

    AST_OUT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == q_ep && q_tok == 2'b01) |-> q_allow == rdata[2]); // R6

    AST_SETUP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == q_ep && q_tok == 2'b11) |-> q_allow == (rdata[2] & rdata[1] & ~rdata[3])); // R7

    AST_STALL_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_set && !sie_rst) |=> (q_ep != $past(stall_ep)) || q_stalled); // R9

    AST_STALL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (q_stalled && !sie_rst && !(wr_en && addr == q_ep && !wdata[0]))
            |=> (q_ep != $past(q_ep)) || q_stalled); // R8

    AST_ENGINE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        sie_rst |=> !q_stalled); // R10

endmodule

bind ep_ctl_bank ep_ctl_bank_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/sim_ep_ctl_bank.sv
`timescale 1ns/1ps
module sim_ep_ctl_bank;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sie_rst = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [3:0] q_ep = '0;
    logic [1:0] q_tok = '0;
    logic       q_allow, q_hs, q_stalled;
    logic       stall_set = 1'b0;
    logic [3:0] stall_ep = '0;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [4:0] mdl [16];

    always #2.5 clk = ~clk;

    ep_ctl_bank u0 (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one clock cycle with given strobes; model updated after the edge
    task automatic cyc(input bit w, input logic [3:0] a, input logic [7:0] d,
                       input bit s, input logic [3:0] se, input bit r);
        @(negedge clk);
        wr_en = w; addr = a; wdata = d; stall_set = s; stall_ep = se; sie_rst = r;
        @(negedge clk);
        wr_en = 1'b0; stall_set = 1'b0; sie_rst = 1'b0;
        if (w) mdl[a] = d[4:0];
        if (s) mdl[se][0] = 1'b1;
        if (r) for (int i = 0; i < 16; i++) mdl[i][0] = 1'b0;
    endtask

    task automatic check_ep(input int ep, input string tag);
        logic [4:0] m;
        bit exp_allow;
        m = mdl[ep];
        addr = 4'(ep);
        #0.2;
        chk(rdata == {3'b000, m}, {tag, " R2 readback"}, rdata, {3'b000, m});
        for (int t = 0; t < 4; t++) begin
            q_ep = 4'(ep); q_tok = 2'(t);
            #0.2;
            case (t)
                1: exp_allow = m[2];
                2: exp_allow = m[1];
                3: exp_allow = m[2] & m[1] & ~m[3];
                default: exp_allow = 1'b0;
            endcase
            chk(q_allow == exp_allow, (t == 3) ? {tag, " R7 setup"} : {tag, " R6 in/out"},
                q_allow, exp_allow);
        end
        chk(q_hs == m[4], {tag, " R4 handshake"}, q_hs, m[4]);
        chk(q_stalled == m[0], {tag, " R5 stall"}, q_stalled, m[0]);
    endtask

    task automatic check_all(input string tag);
        for (int e = 0; e < 16; e++) check_ep(e, tag);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset");

        // R2/R4..R7: exhaustive values per endpoint; R3 via full scan afterwards
        for (int e = 0; e < 16; e++) begin
            for (int v = 0; v < 256; v++) begin
                cyc(1'b1, 4'(e), 8'(v), 1'b0, '0, 1'b0);
                check_ep(e, "sweep");
            end
        end
        for (int e = 0; e < 16; e++) cyc(1'b1, 4'(e), 8'((e * 37 + 11) & 8'hFE), 1'b0, '0, 1'b0);
        check_all("R3 isolation");

        // R8: hardware stall sets only bit 0, sticks through idle cycles
        cyc(1'b0, 4'd0, 8'h00, 1'b1, 4'd6, 1'b0);
        cyc(1'b0, 4'd0, 8'h00, 1'b0, 4'd0, 1'b0);
        cyc(1'b0, 4'd0, 8'h00, 1'b0, 4'd0, 1'b0);
        check_all("R8 sticky");
        // R8: software clears it
        cyc(1'b1, 4'd6, {3'b111, mdl[6][4:1], 1'b0}, 1'b0, '0, 1'b0);
        check_all("R8 sw clear");

        // R9: hw set vs sw clear, same endpoint, same cycle
        cyc(1'b1, 4'd9, 8'h16, 1'b1, 4'd9, 1'b0);
        check_all("R9 collide");
        // hw set on one endpoint while software writes another
        cyc(1'b1, 4'd2, 8'h0A, 1'b1, 4'd3, 1'b0);
        check_all("R9 split");

        // R10: engine reset clears every stall, keeps other bits
        for (int e = 0; e < 16; e += 3) cyc(1'b0, 4'd0, 8'h00, 1'b1, 4'(e), 1'b0);
        cyc(1'b0, 4'd0, 8'h00, 1'b0, 4'd0, 1'b1);
        check_all("R10 engine reset");
        // R10: engine reset beats stall_set, write of other bits still lands
        cyc(1'b1, 4'd12, 8'h1F, 1'b1, 4'd12, 1'b1);
        check_all("R10 override");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule